// File: doc/BRIEF.md
# Simultaneous-Sample Conversion Sequencer

This block is the digital control core of a four-channel converter that samples all of its inputs at one instant and then digitizes them one after another. A convert-start strobe, which need not be synchronous to the system clock, launches a sequence. At the start the block freezes the channel set, the auxiliary input choice and the per-channel sample values. It then works through the chosen channels in fixed time slots and holds an active-low busy flag low for the whole run.

The analog sample-and-hold and the successive-approximation core are outside this block. Each is replaced by a digital code input per channel, and that input is sampled at the start of the sequence. Results go into four result registers. A host reads them over a parallel bus that uses an active-low chip select, an active-low read strobe and a two-bit address.

The host keeps seeing the previous set of results until one cycle before busy rises. At that cycle every converted channel switches to its new value together. Between sequences there is a fixed acquisition window, and the sample-and-hold needs that window before it can take a new sample.

Top module: `conv_seq_top`

## Requirements
- R1: After reset all four result registers read as zero and `busy_n` is high.
- R2: A rising edge on `convst` starts a sequence. `busy_n` falls on the third rising clock edge after the first edge at which `convst` is high, which allows for two synchronizer flops and one edge-detect flop. A level held high starts only one sequence.
- R3: Once started, `busy_n` stays low for exactly n×40 clock cycles, where n is the number of channels the mode converts.
- R4: `mode` selects the channels: 00 gives channels 2 and 3; 01 gives 2, 3 and AUX; 10 gives 1, 2 and 3; 11 gives 1, 2, 3 and AUX. Registers of channels that are not converted keep their earlier contents.
- R5: `aux_sel` values 00, 01, 10 and 11 pick auxiliary input 0, 1, 2 and 3 as the AUX result. Input k sits at `aux_codes[11k+10:11k]`.
- R6: `mode`, `aux_sel` and all code inputs are captured at the start edge. Changes to them while `busy_n` is low have no effect on that sequence.
- R7: The previous results stay readable up to n×40−2 cycles after the start edge. From n×40−1 cycles after it, every converted register holds its new value.
- R8: A result is an 11-bit twos-complement value carried on `rd_data[11:1]`. `rd_data[0]` is always 0.
- R9: Address 00 reads channel 1, 01 reads channel 2, 10 reads channel 3 and 11 reads AUX.
- R10: `rd_en` is high, and `rd_data` carries a register, only when `cs_n` and `rd_n` are both low. At all other times `rd_en` is low and `rd_data` is zero.
- R11: A `convst` rising edge that arrives while `busy_n` is low is discarded. It does not start a later sequence.
- R12: A `convst` edge is also discarded during the acquisition window of 20 cycles after `busy_n` rises. `busy_n` can fall again only after more than 20 cycles high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| convst | input | 1 | Convert-start strobe, may be asynchronous |
| mode | input | 2 | Channel-set select |
| aux_sel | input | 2 | Auxiliary input select |
| vin1_code | input | 11 | Digital stand-in for the channel 1 conversion |
| vin2_code | input | 11 | Digital stand-in for the channel 2 conversion |
| vin3_code | input | 11 | Digital stand-in for the channel 3 conversion |
| aux_codes | input | 44 | Four auxiliary codes, input k in bits 11k+10:11k |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr | input | 2 | Result register address |
| busy_n | output | 1 | Low while a sequence runs |
| rd_data | output | 12 | Read data, result on bits 11:1 |
| rd_en | output | 1 | High while the bus is driven |

## Verification
The bench holds a read open on channel 2 across each sequence. This pins down the one-cycle gap between the switch to new data and the rise of busy. A commit that came one cycle early or one cycle late, or a busy count that was off by a slot, would show as old data at the wrong cycle or as busy rising early.

In the middle of each run the bench scrambles the mode, the auxiliary select and the codes. A design that read these live instead of from a snapshot would store the scrambled values. Further tests raise convst during busy and inside the acquisition window. A design that queued such edges, or ignored the window, would start an extra sequence and drop busy without a new request. Every mode and every auxiliary select is run, and the bench checks that registers for skipped channels keep their values.

// File: rtl/conv_seq_pkg.sv
// Package: shared channel type and mode decoding for the conversion sequencer.
// Assumes four result channels whose order is fixed at channel 1, 2, 3, then AUX.
package conv_seq_pkg;

    localparam int NUM_CH = 4;

    typedef enum logic [1:0] {
        CH_V1  = 2'd0,
        CH_V2  = 2'd1,
        CH_V3  = 2'd2,
        CH_AUX = 2'd3
    } ch_e;

    // Number of slots that a channel-set code asks for.
    function automatic logic [2:0] slots_for_mode(input logic [1:0] m);
        logic [2:0] n;
        n = 3'd2 + {2'b00, m[1]} + {2'b00, m[0]};
        return n;
    endfunction

    // Channel converted in slot s under mode m.
    function automatic ch_e slot_channel(input logic [1:0] m, input logic [1:0] s);
        logic [1:0] idx;
        idx = m[1] ? s : s + 2'd1;
        return ch_e'(idx);
    endfunction

endpackage

// File: rtl/cs_sync_edge.sv
// Module: brings an asynchronous strobe into the clock domain and emits
// a one-cycle pulse on its rising edge.
// Assumes the strobe stays high for longer than one clock period.
module cs_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Synchronizer chain, one flop per stage.
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    // Delayed copy used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/cs_sequencer.sv
// Module: slot timer. It starts a sequence, steps through the selected
// channels in slots of SLOT_CYCLES, drives busy, and marks the capture
// and commit points. After the run it blocks new starts for ACQ_CYCLES.
// Assumes SLOT_CYCLES >= 3. A capture falls three cycles before a slot
// ends, so the last result is stored before the commit cycle.
module cs_sequencer
    import conv_seq_pkg::*;
#(
    parameter int SLOT_CYCLES = 40,
    parameter int ACQ_CYCLES  = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise,
    input  logic [1:0] mode,
    output logic       start,
    output logic       busy_n,
    output logic       slot_done,
    output ch_e        slot_ch,
    output logic       commit
);
    localparam int SW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam int HW = $clog2(ACQ_CYCLES + 1) + 1;
    localparam logic [SW-1:0] SLOT_LAST = SW'(SLOT_CYCLES - 1);
    localparam logic [SW-1:0] SLOT_CMT  = SW'(SLOT_CYCLES - 2);
    localparam logic [SW-1:0] SLOT_CAP  = SW'(SLOT_CYCLES - 3);

    logic [SW-1:0] slot_cnt;
    logic [1:0]    slot_idx;
    logic [2:0]    nslots_q;
    logic [1:0]    mode_q;
    logic [HW-1:0] hold_cnt;
    logic          last_slot;
    logic          slot_end;

    // Start only when idle and outside the acquisition window.
    assign start     = rise & busy_n & (hold_cnt == '0);
    assign last_slot = ({1'b0, slot_idx} == nslots_q - 3'd1);
    assign slot_end  = ~busy_n & (slot_cnt == SLOT_LAST);
    assign slot_done = ~busy_n & (slot_cnt == SLOT_CAP);
    assign commit    = ~busy_n & last_slot & (slot_cnt == SLOT_CMT);
    assign slot_ch   = slot_channel(mode_q, slot_idx);

    // Sequence state: busy flag, slot counters, captured mode, holdoff.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_n   <= 1'b1;
            slot_cnt <= '0;
            slot_idx <= '0;
            nslots_q <= 3'd2;
            mode_q   <= '0;
            hold_cnt <= '0;
        end else if (start) begin
            busy_n   <= 1'b0;
            slot_cnt <= '0;
            slot_idx <= '0;
            mode_q   <= mode;
            nslots_q <= slots_for_mode(mode);
        end else if (!busy_n) begin
            if (slot_end) begin
                slot_cnt <= '0;
                if (last_slot) begin
                    busy_n   <= 1'b1;
                    hold_cnt <= HW'(ACQ_CYCLES);
                end else begin
                    slot_idx <= slot_idx + 2'd1;
                end
            end else begin
                slot_cnt <= slot_cnt + 1'b1;
            end
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

endmodule

// File: rtl/cs_result_bank.sv
// Module: samples every channel code at the start, moves each sample into a
// pending slot when its slot finishes, and copies all finished channels to
// the host-visible registers at once on commit.
// Assumes commit comes after the last slot_done of the same sequence.
module cs_result_bank
    import conv_seq_pkg::*;
#(
    parameter int DATA_W = 11
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [1:0]               aux_sel,
    input  logic [DATA_W-1:0]        vin1_code,
    input  logic [DATA_W-1:0]        vin2_code,
    input  logic [DATA_W-1:0]        vin3_code,
    input  logic [4*DATA_W-1:0]      aux_codes,
    input  logic                     slot_done,
    input  ch_e                      slot_ch,
    input  logic                     commit,
    output logic [NUM_CH*DATA_W-1:0] host_regs
);
    logic [DATA_W-1:0] snap    [NUM_CH];
    logic [DATA_W-1:0] pend    [NUM_CH];
    logic [DATA_W-1:0] host_q  [NUM_CH];
    logic [NUM_CH-1:0] done_mask;
    logic [DATA_W-1:0] aux_pick;

    // Auxiliary input chosen by the select lines.
    always_comb begin
        aux_pick = aux_codes[aux_sel*DATA_W +: DATA_W];
    end

    // Sample-and-hold stand-in: freeze all inputs at the start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) snap[i] <= '0;
        end else if (start) begin
            snap[CH_V1]  <= vin1_code;
            snap[CH_V2]  <= vin2_code;
            snap[CH_V3]  <= vin3_code;
            snap[CH_AUX] <= aux_pick;
        end
    end

    // Per-slot result capture and record of finished channels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_mask <= '0;
            for (int i = 0; i < NUM_CH; i++) pend[i] <= '0;
        end else if (start) begin
            done_mask <= '0;
        end else if (slot_done) begin
            pend[slot_ch]      <= snap[slot_ch];
            done_mask[slot_ch] <= 1'b1;
        end
    end

    // Host registers, one per channel, updated together on commit.
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_host
            always_ff @(posedge clk) begin
                if (!rst_n)                       host_q[c] <= '0;
                else if (commit && done_mask[c])  host_q[c] <= pend[c];
            end
            assign host_regs[c*DATA_W +: DATA_W] = host_q[c];
        end
    endgenerate

endmodule

// File: rtl/cs_host_port.sv
// Module: read side of the parallel bus. It selects a result register by
// address and places it on the upper bits with bit 0 held low.
// Assumes cs_n and rd_n are synchronous to the host and used as levels.
module cs_host_port
    import conv_seq_pkg::*;
#(
    parameter int DATA_W = 11
) (
    input  logic                     cs_n,
    input  logic                     rd_n,
    input  logic [1:0]               addr,
    input  logic [NUM_CH*DATA_W-1:0] host_regs,
    output logic [DATA_W:0]          rd_data,
    output logic                     rd_en
);
    // Address decode and bus gating.
    always_comb begin
        rd_en   = ~cs_n & ~rd_n;
        rd_data = '0;
        if (rd_en) rd_data = {host_regs[addr*DATA_W +: DATA_W], 1'b0};
    end

endmodule

// File: rtl/conv_seq_top.sv
// Module: top of the conversion sequencer. It connects the strobe
// synchronizer, slot timer, result bank and host read port.
// Assumes mode and aux_sel are steady for two cycles before a start.
module conv_seq_top
    import conv_seq_pkg::*;
#(
    parameter int DATA_W      = 11,
    parameter int SLOT_CYCLES = 40,
    parameter int ACQ_CYCLES  = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 convst,
    input  logic [1:0]           mode,
    input  logic [1:0]           aux_sel,
    input  logic [DATA_W-1:0]    vin1_code,
    input  logic [DATA_W-1:0]    vin2_code,
    input  logic [DATA_W-1:0]    vin3_code,
    input  logic [4*DATA_W-1:0]  aux_codes,
    input  logic                 cs_n,
    input  logic                 rd_n,
    input  logic [1:0]           addr,
    output logic                 busy_n,
    output logic [DATA_W:0]      rd_data,
    output logic                 rd_en
);
    logic                     rise;
    logic                     start;
    logic                     slot_done;
    ch_e                      slot_ch;
    logic                     commit;
    logic [NUM_CH*DATA_W-1:0] host_regs;

    cs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(convst), .rise(rise)
    );

    cs_sequencer #(.SLOT_CYCLES(SLOT_CYCLES), .ACQ_CYCLES(ACQ_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .rise(rise), .mode(mode),
        .start(start), .busy_n(busy_n), .slot_done(slot_done),
        .slot_ch(slot_ch), .commit(commit)
    );

    cs_result_bank #(.DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .start(start), .aux_sel(aux_sel),
        .vin1_code(vin1_code), .vin2_code(vin2_code), .vin3_code(vin3_code),
        .aux_codes(aux_codes), .slot_done(slot_done), .slot_ch(slot_ch),
        .commit(commit), .host_regs(host_regs)
    );

    cs_host_port #(.DATA_W(DATA_W)) u_port (
        .cs_n(cs_n), .rd_n(rd_n), .addr(addr), .host_regs(host_regs),
        .rd_data(rd_data), .rd_en(rd_en)
    );

endmodule

// File: rtl/conv_seq_chk.sv
// Module: property checker for conv_seq_top, bound in below. It watches
// only the top-level ports and keeps its own counters.
module conv_seq_chk
    import conv_seq_pkg::*;
#(
    parameter int DATA_W      = 11,
    parameter int SLOT_CYCLES = 40,
    parameter int ACQ_CYCLES  = 20
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy_n,
    input logic [1:0]      mode,
    input logic            cs_n,
    input logic            rd_n,
    input logic [1:0]      addr,
    input logic [DATA_W:0] rd_data,
    input logic            rd_en
);
    logic [15:0] lo_cnt;
    logic [15:0] hi_cnt;
    logic [1:0]  mode_prev;
    logic [1:0]  mode_cap;
    logic        busy_prev;
    logic        seen_rise;
    logic [15:0] exp_len;

    assign exp_len = 16'(slots_for_mode(mode_cap)) * 16'(SLOT_CYCLES);

    // Measure how long busy stays low and how long it stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt    <= '0;
            hi_cnt    <= '0;
            mode_prev <= '0;
            mode_cap  <= '0;
            busy_prev <= 1'b1;
            seen_rise <= 1'b0;
        end else begin
            mode_prev <= mode;
            busy_prev <= busy_n;
            if (!busy_n) begin
                hi_cnt <= '0;
                if (busy_prev) begin
                    lo_cnt   <= 16'd1;
                    mode_cap <= mode_prev;
                end else begin
                    lo_cnt <= lo_cnt + 16'd1;
                end
            end else begin
                if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 16'd1;
                if (!busy_prev) seen_rise <= 1'b1;
            end
        end
    end

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_n && !busy_prev) |-> (lo_cnt == exp_len)); // R3

    AST_ACQ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n && busy_prev && seen_rise) |-> (hi_cnt > 16'(ACQ_CYCLES))); // R12

    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (!rd_en && rd_data == '0)); // R10

    AST_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_data[0] == 1'b0)); // R8

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en) && $stable(addr) && busy_n && busy_prev)
        |-> $stable(rd_data)); // R7

endmodule

bind conv_seq_top conv_seq_chk #(
    .DATA_W(DATA_W), .SLOT_CYCLES(SLOT_CYCLES), .ACQ_CYCLES(ACQ_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy_n(busy_n), .mode(mode),
    .cs_n(cs_n), .rd_n(rd_n), .addr(addr), .rd_data(rd_data), .rd_en(rd_en)
);

// File: tb/conv_seq_top_test.sv
`timescale 1ns/100ps
// Bench: directed tests for conv_seq_top, one task per scenario.
module conv_seq_top_test;
    localparam int W    = 11;
    localparam int SLOT = 40;
    localparam int ACQ  = 20;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           convst = 1'b0;
    logic [1:0]     mode = '0;
    logic [1:0]     aux_sel = '0;
    logic [W-1:0]   vin1_code = '0, vin2_code = '0, vin3_code = '0;
    logic [4*W-1:0] aux_codes = '0;
    logic           cs_n = 1'b1, rd_n = 1'b1;
    logic [1:0]     addr = '0;
    logic           busy_n;
    logic [W:0]     rd_data;
    logic           rd_en;

    int n_chk = 0;
    int n_err = 0;
    logic [W-1:0] expv [4];

    always #2.5 clk = ~clk;

    conv_seq_top uut (
        .clk(clk), .rst_n(rst_n), .convst(convst), .mode(mode), .aux_sel(aux_sel),
        .vin1_code(vin1_code), .vin2_code(vin2_code), .vin3_code(vin3_code),
        .aux_codes(aux_codes), .cs_n(cs_n), .rd_n(rd_n), .addr(addr),
        .busy_n(busy_n), .rd_data(rd_data), .rd_en(rd_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    // Reads one register through the bus and compares it with the model.
    task automatic read_chk(input string req, input logic [1:0] a);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #0.1;
        chk(req, {20'd0, rd_data}, {20'd0, expv[a], 1'b0});
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 4; i++) expv[i] = '0;
        chk("R1 busy after reset", {31'd0, busy_n}, 32'd1);
        for (int i = 0; i < 4; i++) read_chk("R1 register zero after reset", 2'(i));
    endtask

    // One full sequence with latency, busy length, boundary and snapshot checks.
    task automatic run_seq(input logic [1:0] m, input logic [1:0] a,
                           input logic [W-1:0] c1, input logic [W-1:0] c2,
                           input logic [W-1:0] c3, input logic [4*W-1:0] ax,
                           input bit poke);
        int total;
        logic [W-1:0] nv [4];
        mode = m; aux_sel = a;
        vin1_code = c1; vin2_code = c2; vin3_code = c3; aux_codes = ax;
        total = (2 + int'(m[1]) + int'(m[0])) * SLOT;
        for (int i = 0; i < 4; i++) nv[i] = expv[i];
        if (m[1]) nv[0] = c1;
        nv[1] = c2;
        nv[2] = c3;
        if (m[0]) nv[3] = ax[a*W +: W];
        repeat (ACQ + 4) @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = 2'b01;
        #0.5 convst = 1'b1;
        @(negedge clk);
        chk("R2 busy high one cycle after strobe", {31'd0, busy_n}, 32'd1);
        @(negedge clk);
        chk("R2 busy high two cycles after strobe", {31'd0, busy_n}, 32'd1);
        @(negedge clk);
        chk("R2 busy low three cycles after strobe", {31'd0, busy_n}, 32'd0);
        convst = 1'b0;
        for (int k = 1; k <= total; k++) begin
            @(negedge clk);
            if (k == 5) begin
                // R6: scramble every captured input mid-sequence.
                mode = ~m; aux_sel = ~a;
                vin1_code = c1 ^ 11'h155; vin2_code = c2 ^ 11'h2AA;
                vin3_code = c3 ^ 11'h0F0; aux_codes = ~ax;
            end
            if (poke && k == 10) convst = 1'b1;
            if (poke && k == 15) convst = 1'b0;
            if (k == total - 2)
                chk("R7 old data before boundary", {20'd0, rd_data}, {20'd0, expv[1], 1'b0});
            if (k == total - 1) begin
                chk("R7 new data at boundary", {20'd0, rd_data}, {20'd0, nv[1], 1'b0});
                chk("R3 busy still low at n*40-1", {31'd0, busy_n}, 32'd0);
            end
            if (k == total)
                chk("R3 busy high at n*40", {31'd0, busy_n}, 32'd1);
        end
        for (int i = 0; i < 4; i++) expv[i] = nv[i];
        for (int i = 0; i < 4; i++) read_chk("R4 R5 R6 R9 register contents", 2'(i));
        if (poke) begin
            for (int k = 0; k < ACQ + 20; k++) begin
                @(negedge clk);
                if (busy_n !== 1'b1) begin
                    chk("R11 no restart from edge during busy", {31'd0, busy_n}, 32'd1);
                    break;
                end
            end
            chk("R11 idle after ignored edge", {31'd0, busy_n}, 32'd1);
        end
    endtask

    task automatic t_bus_gate;
        cs_n = 1'b1; rd_n = 1'b0; addr = 2'b10;
        #0.1;
        chk("R10 no drive with cs_n high", {19'd0, rd_en, rd_data}, 32'd0);
        cs_n = 1'b0; rd_n = 1'b1;
        #0.1;
        chk("R10 no drive with rd_n high", {19'd0, rd_en, rd_data}, 32'd0);
        cs_n = 1'b0; rd_n = 1'b0;
        #0.1;
        chk("R10 drive with both low", {31'd0, rd_en}, 32'd1);
        chk("R8 bit zero low", {31'd0, rd_data[0]}, 32'd0);
        chk("R8 value on upper bits", {21'd0, rd_data[W:1]}, {21'd0, expv[2]});
    endtask

    // Edge inside the acquisition window is dropped; a later edge works.
    task automatic t_holdoff;
        bit fell;
        run_seq(2'b00, 2'b00, 11'h011, 11'h022, 11'h033, {4{11'h044}}, 1'b0);
        convst = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (busy_n !== 1'b1) begin
                chk("R12 edge in window ignored", {31'd0, busy_n}, 32'd1);
                break;
            end
        end
        chk("R12 idle after window edge", {31'd0, busy_n}, 32'd1);
        convst = 1'b0;
        mode = 2'b00; vin2_code = 11'h3C3; vin3_code = 11'h5A5;
        repeat (3) @(negedge clk);
        convst = 1'b1;
        fell = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (busy_n === 1'b0) fell = 1'b1;
        end
        chk("R12 edge after window starts", {31'd0, fell}, 32'd1);
        convst = 1'b0;
        for (int k = 0; k < 200 && busy_n !== 1'b1; k++) @(negedge clk);
        expv[1] = 11'h3C3; expv[2] = 11'h5A5;
        read_chk("R12 result of late start", 2'b01);
        read_chk("R12 result of late start", 2'b10);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        run_seq(2'b00, 2'b00, 11'h101, 11'h202, 11'h303, {11'h444, 11'h333, 11'h222, 11'h111}, 1'b0);
        run_seq(2'b01, 2'b10, 11'h7FF, 11'h400, 11'h001, {11'h0AA, 11'h0BB, 11'h0CC, 11'h0DD}, 1'b0);
        run_seq(2'b10, 2'b11, 11'h155, 11'h2AA, 11'h3FF, {11'h600, 11'h500, 11'h700, 11'h100}, 1'b1);
        run_seq(2'b11, 2'b01, 11'h0F0, 11'h70F, 11'h123, {11'h456, 11'h789, 11'h6AB, 11'h4CD}, 1'b0);
        run_seq(2'b11, 2'b00, 11'h031, 11'h042, 11'h053, {11'h010, 11'h020, 11'h030, 11'h7C0}, 1'b1);
        t_bus_gate();
        t_holdoff();
        summary();
        $finish;
    end

endmodule